// File: doc/BRIEF.md
# Ripple-Carry Adder Self-Test Sequencer

This block is a built-in self-test controller for an N-bit ripple-carry adder. When started, it drives the operands and the carry-in of the adder under test through a fixed set of ten vectors. The vectors are chosen so that every full-adder cell sees all eight combinations of its inputs. The ten vectors are three carry-free vectors, three vectors in which a carry runs the whole length of the chain, and four vectors of alternating bits in which a carry is absorbed or generated in every second cell.

Each vector is held for a configurable number of settle cycles. On the last cycle of that interval, the adder's sum and carry-out are compared with the expected value a + b + cin, which the block computes itself at N+1 bits. Checking carries on after a mismatch. A sticky fail flag records that any mismatch occurred, and the index of the first failing vector is latched. A done flag marks the end of the run and stays high until the next start.

Top module: `adder_bist_seq`

## Requirements
- R1: After synchronous reset, `done`, `pass` and `fail` are 0, `fail_idx` is 0, and `tst_a`, `tst_b` and `tst_cin` are all 0.
- R2: A `start` sampled high while no run is active begins vector 0 at that clock edge. Vector k is driven for exactly SETTLE cycles, beginning SETTLE*k cycles after that edge, in the order 0 to 9. Each vector holds its operands stable.
- R3: Vectors 0 to 5 (a, b, cin) are: (zeros, zeros, 0), (zeros, ones, 0), (ones, zeros, 0), (ones, zeros, 1), (zeros, ones, 1), (ones, ones, 1).
- R4: Vectors 6 to 9 set a = b. Pattern P has bit i = 1 for even i, and pattern Q has bit i = 1 for odd i, each truncated to N bits. The vectors are: 6 = (P, 0), 7 = (Q, 1), 8 = (Q, 0), 9 = (P, 1).
- R5: On the last settle cycle of every vector, {`dut_cout`, `dut_sum`} is compared with a + b + cin at N+1 bits. A difference in the carry-out alone counts as a mismatch.
- R6: A mismatch sets `fail`, which stays set for the rest of the run. `fail_idx` holds the index (0 to 9) of the first mismatching vector, and later mismatches do not change it.
- R7: `done` rises SETTLE*10 cycles after the accepting start edge and stays high until the next accepted start. `pass` is 1 exactly when `done` is 1 and `fail` is 0.
- R8: `start` while a run is active has no effect on the vector order or timing.
- R9: An accepted start clears `done`, `fail` and `fail_idx` at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test run when not running |
| tst_a | output | WIDTH | Operand A to adder under test |
| tst_b | output | WIDTH | Operand B to adder under test |
| tst_cin | output | 1 | Carry-in to adder under test |
| dut_sum | input | WIDTH | Sum from adder under test |
| dut_cout | input | 1 | Carry-out from adder under test |
| done | output | 1 | Run complete, held until next start |
| pass | output | 1 | Run complete with no mismatch |
| fail | output | 1 | Sticky mismatch flag |
| fail_idx | output | 4 | Index of first failing vector |

## Verification
The comparison for the final vector, 9, takes place in the same cycle in which the sequencer decides to end the run. At the following edge, `fail` and `done` therefore both rise. The bench provokes this case with a model adder that corrupts its result only for the operands of vector 9. It then expects `done` = 1, `fail` = 1, `pass` = 0 and `fail_idx` = 9 together. A fault injected on every other vector index in turn checks that the latched index always follows the vector, and never the moment the run ends.

// File: rtl/adder_bist_pkg.sv
package adder_bist_pkg;

    localparam int NUM_VECS = 10;
    localparam int IDX_W    = 4;

    typedef logic [IDX_W-1:0] vec_idx_t;

    localparam vec_idx_t LAST_IDX = vec_idx_t'(NUM_VECS - 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE
    } seq_state_t;

    // operand shape: all zero, all one, ones on even bits, ones on odd bits
    typedef enum logic [1:0] {
        PAT_ZERO,
        PAT_ONES,
        PAT_EVEN,
        PAT_ODD
    } pat_kind_t;

    typedef struct packed {
        pat_kind_t a_kind;
        pat_kind_t b_kind;
        logic      cin;
    } vec_recipe_t;

    function automatic vec_recipe_t recipe_of(vec_idx_t idx);
        vec_recipe_t r;
        case (idx)
            4'd0:    r = '{PAT_ZERO, PAT_ZERO, 1'b0};
            4'd1:    r = '{PAT_ZERO, PAT_ONES, 1'b0};
            4'd2:    r = '{PAT_ONES, PAT_ZERO, 1'b0};
            4'd3:    r = '{PAT_ONES, PAT_ZERO, 1'b1};
            4'd4:    r = '{PAT_ZERO, PAT_ONES, 1'b1};
            4'd5:    r = '{PAT_ONES, PAT_ONES, 1'b1};
            4'd6:    r = '{PAT_EVEN, PAT_EVEN, 1'b0};
            4'd7:    r = '{PAT_ODD,  PAT_ODD,  1'b1};
            4'd8:    r = '{PAT_ODD,  PAT_ODD,  1'b0};
            4'd9:    r = '{PAT_EVEN, PAT_EVEN, 1'b1};
            default: r = '{PAT_ZERO, PAT_ZERO, 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/abist_ctrl.sv
module abist_ctrl
    import adder_bist_pkg::*;
#(
    parameter int SETTLE = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output logic     running,
    output logic     sample,
    output logic     clear,
    output logic     done,
    output vec_idx_t idx
);

    localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE - 1);

    seq_state_t       state_q;
    vec_idx_t         idx_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        idx_q   <= '0;
                        cnt_q   <= '0;
                    end
                end
                ST_RUN: begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_q <= '0;
                        if (idx_q == LAST_IDX) state_q <= ST_DONE;
                        else                   idx_q   <= idx_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign running = (state_q == ST_RUN);
    assign sample  = running && (cnt_q == CNT_LAST);
    assign done    = (state_q == ST_DONE);
    assign clear   = start && !running;
    assign idx     = idx_q;

    AST_RUN_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> (idx == '0)); // R2

    AST_IDX_LIMIT: assert property (@(posedge clk) disable iff (rst)
        running |-> (idx <= LAST_IDX)); // R2

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (running && start && !sample) |=> (running && $stable(idx))); // R8

endmodule

// File: rtl/abist_pattern_gen.sv
module abist_pattern_gen
    import adder_bist_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             en,
    input  vec_idx_t         idx,
    output logic [WIDTH-1:0] op_a,
    output logic [WIDTH-1:0] op_b,
    output logic             op_cin
);

    logic [WIDTH-1:0] alt_even;
    logic [WIDTH-1:0] alt_odd;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_seed
            assign alt_even[gi] = ((gi % 2) == 0) ? 1'b1 : 1'b0;
            assign alt_odd[gi]  = ((gi % 2) == 1) ? 1'b1 : 1'b0;
        end
    endgenerate

    function automatic logic [WIDTH-1:0] shape(pat_kind_t k,
                                               logic [WIDTH-1:0] ev,
                                               logic [WIDTH-1:0] od);
        case (k)
            PAT_ZERO: return '0;
            PAT_ONES: return '1;
            PAT_EVEN: return ev;
            PAT_ODD:  return od;
            default:  return '0;
        endcase
    endfunction

    vec_recipe_t rec;

    always_comb begin
        rec    = recipe_of(idx);
        op_a   = '0;
        op_b   = '0;
        op_cin = 1'b0;
        if (en) begin
            op_a   = shape(rec.a_kind, alt_even, alt_odd);
            op_b   = shape(rec.b_kind, alt_even, alt_odd);
            op_cin = rec.cin;
        end
    end

endmodule

// File: rtl/abist_checker.sv
module abist_checker
    import adder_bist_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             sample,
    input  vec_idx_t         idx,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             op_cin,
    input  logic [WIDTH-1:0] res_sum,
    input  logic             res_cout,
    output logic             fail,
    output vec_idx_t         fail_idx
);

    localparam int RW = WIDTH + 1;

    logic [RW-1:0] expected;
    logic [RW-1:0] observed;
    logic          mismatch;
    logic          fail_q;
    vec_idx_t      fidx_q;

    always_comb begin
        expected = {1'b0, op_a} + {1'b0, op_b} + RW'(op_cin);
        observed = {res_cout, res_sum};
        mismatch = (expected != observed);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail_q <= 1'b0;
            fidx_q <= '0;
        end else if (sample && mismatch) begin
            fail_q <= 1'b1;
            if (!fail_q) fidx_q <= idx;
        end
    end

    assign fail     = fail_q;
    assign fail_idx = fidx_q;

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fail && !clear) |=> fail); // R6

    AST_FIRST_IDX_KEPT: assert property (@(posedge clk) disable iff (rst)
        (fail && !clear) |=> $stable(fail_idx)); // R6

    AST_FAIL_ONLY_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (!fail && !sample) |=> !fail); // R5

    AST_CLEAR_RESETS: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!fail && fail_idx == '0)); // R9

endmodule

// File: rtl/adder_bist_seq.sv
module adder_bist_seq
    import adder_bist_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int SETTLE = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic [WIDTH-1:0] tst_a,
    output logic [WIDTH-1:0] tst_b,
    output logic             tst_cin,
    input  logic [WIDTH-1:0] dut_sum,
    input  logic             dut_cout,
    output logic             done,
    output logic             pass,
    output logic             fail,
    output logic [3:0]       fail_idx
);

    logic     running;
    logic     sample;
    logic     clear;
    vec_idx_t idx;
    vec_idx_t first_bad;

    abist_ctrl #(.SETTLE(SETTLE)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .running (running),
        .sample  (sample),
        .clear   (clear),
        .done    (done),
        .idx     (idx)
    );

    abist_pattern_gen #(.WIDTH(WIDTH)) u_pat (
        .en     (running),
        .idx    (idx),
        .op_a   (tst_a),
        .op_b   (tst_b),
        .op_cin (tst_cin)
    );

    abist_checker #(.WIDTH(WIDTH)) u_chk (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .sample   (sample),
        .idx      (idx),
        .op_a     (tst_a),
        .op_b     (tst_b),
        .op_cin   (tst_cin),
        .res_sum  (dut_sum),
        .res_cout (dut_cout),
        .fail     (fail),
        .fail_idx (first_bad)
    );

    assign pass     = done && !fail;
    assign fail_idx = first_bad;

    AST_OPS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (running && !sample) |=> ($stable(tst_a) && $stable(tst_b) && $stable(tst_cin))); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !running |-> (tst_a == '0 && tst_b == '0 && !tst_cin)); // R1

endmodule

// File: tb/adder_bist_seq_bench.sv
module adder_bist_seq_bench;

    localparam int W        = 8;
    localparam int SETTLE   = 3;
    localparam int CLK_HALF = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] tst_a, tst_b, dut_sum;
    logic         tst_cin, dut_cout;
    logic         done, pass, fail;
    logic [3:0]   fail_idx;

    int checks = 0;
    int errors = 0;

    // fault injection: two operand-matched slots
    logic         f0_en = 1'b0, f1_en = 1'b0;
    logic [W-1:0] f0_a = '0, f0_b = '0, f1_a = '0, f1_b = '0;
    logic         f0_c = 1'b0, f1_c = 1'b0;
    logic [W:0]   f0_x = '0, f1_x = '0;
    logic [W:0]   full;

    localparam logic [W-1:0] TA [10] = '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00,
                                         8'hFF, 8'h55, 8'hAA, 8'hAA, 8'h55};
    localparam logic [W-1:0] TB [10] = '{8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF,
                                         8'hFF, 8'h55, 8'hAA, 8'hAA, 8'h55};
    localparam logic         TC [10] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1,
                                         1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

    always #CLK_HALF clk = ~clk;

    always_comb begin
        full = {1'b0, tst_a} + {1'b0, tst_b} + {{W{1'b0}}, tst_cin};
        if (f0_en && tst_a == f0_a && tst_b == f0_b && tst_cin == f0_c) full = full ^ f0_x;
        if (f1_en && tst_a == f1_a && tst_b == f1_b && tst_cin == f1_c) full = full ^ f1_x;
        {dut_cout, dut_sum} = full;
    end

    adder_bist_seq #(.WIDTH(W), .SETTLE(SETTLE)) u_adder_bist_seq (
        .clk(clk), .rst(rst), .start(start),
        .tst_a(tst_a), .tst_b(tst_b), .tst_cin(tst_cin),
        .dut_sum(dut_sum), .dut_cout(dut_cout),
        .done(done), .pass(pass), .fail(fail), .fail_idx(fail_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // start pulse; returns half a cycle after the accepting edge
    task automatic launch();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic run_blind();
        launch();
        repeat (10 * SETTLE) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 done", done, 0);
        chk("R1 fail", fail, 0);
        chk("R1 pass", pass, 0);
        chk("R1 ops", {tst_a, tst_b, tst_cin}, 0);

        // table walk: clean adder
        launch();
        for (int k = 0; k < 10; k++) begin
            chk(k < 6 ? "R3 operand a" : "R4 operand a", tst_a, TA[k]);
            chk(k < 6 ? "R3 operand b" : "R4 operand b", tst_b, TB[k]);
            chk(k < 6 ? "R3 carry-in"  : "R4 carry-in",  tst_cin, TC[k]);
            chk("R7 done low during run", done, 0);
            repeat (SETTLE - 1) @(negedge clk);
            chk("R2 vector held", tst_a, TA[k]);
            @(negedge clk);
        end
        chk("R7 done", done, 1);
        chk("R7 pass", pass, 1);
        chk("R5 no false fail", fail, 0);
        chk("R1 ops idle after run", {tst_a, tst_b, tst_cin}, 0);
        repeat (5) @(negedge clk);
        chk("R7 done held", done, 1);

        // fault on each vector index; k=9 coincides with done rising
        for (int k = 0; k < 10; k++) begin
            f0_en = 1'b1; f0_a = TA[k]; f0_b = TB[k]; f0_c = TC[k]; f0_x = 9'h001;
            run_blind();
            chk("R6 fail set", fail, 1);
            chk("R6 first index", fail_idx, k);
            chk("R7 done with fail", done, 1);
            chk("R7 pass low", pass, 0);
        end

        // carry-out only fault on vector 5
        f0_a = TA[5]; f0_b = TB[5]; f0_c = TC[5]; f0_x = 9'h100;
        run_blind();
        chk("R5 cout mismatch", fail, 1);
        chk("R5 cout index", fail_idx, 5);

        // two faults: first index kept, checking continues
        f0_a = TA[2]; f0_b = TB[2]; f0_c = TC[2]; f0_x = 9'h001;
        f1_en = 1'b1; f1_a = TA[7]; f1_b = TB[7]; f1_c = TC[7]; f1_x = 9'h100;
        run_blind();
        chk("R6 earliest kept", fail_idx, 2);
        chk("R6 still failing", fail, 1);

        // R9: restart clears at accepting edge
        f0_en = 1'b0; f1_en = 1'b0;
        launch();
        chk("R9 fail cleared", fail, 0);
        chk("R9 index cleared", fail_idx, 0);
        chk("R9 done cleared", done, 0);
        repeat (10 * SETTLE) @(negedge clk);
        chk("R9 clean pass", pass, 1);

        // R8: start during run ignored
        launch();
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 vector kept", tst_a, TA[1]);
        chk("R8 cin kept", tst_cin, TC[1]);
        repeat (10 * SETTLE - 6) @(negedge clk);
        chk("R8 done not early", done, 0);
        @(negedge clk);
        chk("R8 done on time", done, 1);

        finish_up();
    end

endmodule